// File: doc/BRIEF.md
# TDM Timeslot Data Access Unit

The unit gives a host processor byte-wide access to single timeslots of a serial time-division frame. The frame runs on two serial lines, one upstream and one downstream, and holds twelve byte timeslots of eight bits each. Each timeslot is sent most significant bit first, one bit per clock cycle, and a one-cycle frame sync pulse marks bit 0 of timeslot 0. The unit has two data lanes, lane 0 and lane 1. Each lane has its own data register and its own select register, and both lanes share one control register.

Each lane can do two things. It can capture the byte passing in a chosen timeslot into its data register, and it can send its stored byte in a chosen timeslot. The select register names the timeslot and the line the lane sends on. A lane always captures from the other line. A swap control exchanges the capture selections of the two lanes. A monitor mode gives lane 0 to watching a control channel. When no lane is sending, the unit releases each line in open-drain style. Control and select writes are held in shadow registers and take effect at the next frame sync. Data register writes take effect at once.

Top module: `tdm_access_unit`

## Requirements
- R1: After reset, every host register reads 00h. Host addresses are: 0 control, 1 lane 0 select, 2 lane 1 select, 3 lane 0 data, 4 lane 1 data. A write to a data register can be read back on the next cycle.
- R2: The control register holds six bits: bit 5 monitor, bit 4 lane 1 capture enable, bit 3 lane 0 capture enable, bit 2 lane 1 send enable, bit 1 lane 0 send enable, bit 0 swap. Bits 7 and 6 always read 0.
- R3: A lane whose capture is enabled loads its data register with the byte of its capture timeslot, taken MSB first. The byte is committed once the eighth bit has arrived. The lane captures on the line opposite the one its select register names for sending. A select value has bit 7 = 1 for upstream and bit 7 = 0 for downstream, and bits 3:0 give the timeslot.
- R4: A lane whose capture is disabled keeps its data register unchanged across a frame.
- R5: A lane whose send is enabled drives its stored byte MSB first in its selected timeslot on its selected line. The line's output enable is high for exactly those 8 bits.
- R6: A line that is not being driven shows output high and output enable low. A select timeslot value of 12 to 15 matches no timeslot, so a lane with such a value never drives.
- R7: With swap set, lane 0 captures with the timeslot and opposite line taken from lane 1's select register, and lane 1 captures with those taken from lane 0's. The send timeslot and line of each lane do not change.
- R8: With monitor set, lane 0 captures from its own select register even if its capture enable is 0 and swap is 1. Lane 0 does not drive in this mode. A select value of 08h watches upstream timeslot 8 and 88h watches downstream timeslot 8.
- R9: A control or select write can be read back at once, but it changes line behaviour only from the next frame sync on. A write made partway through a frame does not affect the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | One-cycle pulse marking bit 0 of timeslot 0 |
| up_in | input | 1 | Sampled upstream line |
| dn_in | input | 1 | Sampled downstream line |
| up_out | output | 1 | Upstream drive value, high when released |
| up_oe | output | 1 | Upstream output enable |
| dn_out | output | 1 | Downstream drive value, high when released |
| dn_oe | output | 1 | Downstream output enable |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 3 | Host read address |
| host_rdata | output | 8 | Host read data, combinational |

## Verification
The checks assume that fsync pulses for exactly one cycle and that pulses are at least one frame (96 cycles) apart. They also assume that the host never writes a data register in the same cycle that its lane finishes a capture. The bench meets these conditions by running every frame as 96 consecutive cycles that start with a single sync cycle. It makes all data register writes between frames. The only host write it makes inside a frame is a control write, used to show that such a write is deferred.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   localparam int CTRL_W = 6;

   typedef struct packed {
      logic mon;
      logic in1;
      logic in0;
      logic out1;
      logic out0;
      logic swap;
   } tdm_ctrl_t;

   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_SEL0 = 3'd1,
      A_SEL1 = 3'd2,
      A_DAT0 = 3'd3,
      A_DAT1 = 3'd4
   } tdm_addr_e;

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
   parameter int NUM_TS = 12,
   parameter int BYTE_W = 8,
   parameter int TS_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fsync,
   output logic                      in_frame,
   output logic [TS_W-1:0]           slot,
   output logic [$clog2(BYTE_W)-1:0] bit_idx
);
   localparam int FRAME_BITS = NUM_TS * BYTE_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam int BIT_W      = $clog2(BYTE_W);

   if (BYTE_W != (1 << BIT_W)) begin : g_chk_pow2
      $error("tdm_bit_timer: BYTE_W must be a power of two");
   end
   if (NUM_TS > (1 << TS_W)) begin : g_chk_ts
      $error("tdm_bit_timer: NUM_TS does not fit the timeslot field");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cur;

   // a sync pulse overrides the counter so bit 0 is served in the sync cycle
   assign cur      = fsync ? '0 : cnt_q;
   assign in_frame = (cur < CNT_W'(FRAME_BITS));
   assign slot     = TS_W'(cur >> BIT_W);
   assign bit_idx  = cur[BIT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(FRAME_BITS);   // idle: outside any frame
      end else if (in_frame) begin
         cnt_q <= cur + CNT_W'(1);
      end
   end

endmodule

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
   import tdm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fsync,
   input  logic                   host_wr,
   input  logic [2:0]             host_addr,
   input  logic [BYTE_W-1:0]      host_wdata,
   output tdm_ctrl_t              ctrl_sh,
   output tdm_ctrl_t              ctrl_eff,
   output logic [1:0][BYTE_W-1:0] sel_sh,
   output logic [1:0][BYTE_W-1:0] sel_eff
);
   if (BYTE_W < CTRL_W) begin : g_chk_w
      $error("tdm_cfg_regs: BYTE_W too narrow for the control word");
   end

   tdm_ctrl_t              ctrl_act;
   logic [1:0][BYTE_W-1:0] sel_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_sh <= '0;
         sel_sh  <= '0;
      end else if (host_wr) begin
         case (host_addr)
            A_CTRL:  ctrl_sh   <= tdm_ctrl_t'(host_wdata[CTRL_W-1:0]);
            A_SEL0:  sel_sh[0] <= host_wdata;
            A_SEL1:  sel_sh[1] <= host_wdata;
            default: ;
         endcase
      end
   end

   // active copy only moves on a frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_act <= '0;
         sel_act  <= '0;
      end else if (fsync) begin
         ctrl_act <= ctrl_sh;
         sel_act  <= sel_sh;
      end
   end

   assign ctrl_eff = fsync ? ctrl_sh : ctrl_act;
   assign sel_eff  = fsync ? sel_sh  : sel_act;

endmodule

// File: rtl/tdm_slot_lane.sv
module tdm_slot_lane #(
   parameter int BYTE_W = 8,
   parameter int TS_W   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_frame,
   input  logic [TS_W-1:0]           slot,
   input  logic [$clog2(BYTE_W)-1:0] bit_idx,
   input  logic                      up_in,
   input  logic                      dn_in,
   input  logic                      cap_en,
   input  logic [TS_W-1:0]           cap_ts,
   input  logic                      cap_up,
   input  logic                      drv_en,
   input  logic [TS_W-1:0]           drv_ts,
   input  logic                      host_load,
   input  logic [BYTE_W-1:0]         host_wdata,
   output logic [BYTE_W-1:0]         data_q,
   output logic                      drive,
   output logic                      drv_bit
);
   localparam int BIT_W = $clog2(BYTE_W);

   logic [BYTE_W-2:0] sh_q;
   logic              cap_hit;
   logic              sample;
   logic              last_bit;

   assign cap_hit  = cap_en && in_frame && (slot == cap_ts);
   assign sample   = cap_up ? up_in : dn_in;
   assign last_bit = (bit_idx == BIT_W'(BYTE_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         data_q <= '0;
      end else begin
         if (cap_hit) begin
            sh_q <= {sh_q[BYTE_W-3:0], sample};
         end
         if (host_load) begin
            data_q <= host_wdata;
         end else if (cap_hit && last_bit) begin
            data_q <= {sh_q, sample};   // commit full byte
         end
      end
   end

   assign drive   = drv_en && in_frame && (slot == drv_ts);
   assign drv_bit = data_q[BIT_W'(BYTE_W - 1) - bit_idx];

endmodule

// File: rtl/tdm_access_unit.sv
module tdm_access_unit
   import tdm_pkg::*;
#(
   parameter int NUM_TS = 12,
   parameter int BYTE_W = 8,
   parameter int TS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              up_in,
   input  logic              dn_in,
   output logic              up_out,
   output logic              up_oe,
   output logic              dn_out,
   output logic              dn_oe,
   input  logic              host_wr,
   input  logic [2:0]        host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic [2:0]        host_raddr,
   output logic [BYTE_W-1:0] host_rdata
);
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int LINE_B = BYTE_W - 1;

   if (TS_W >= LINE_B) begin : g_chk_fields
      $error("tdm_access_unit: timeslot field overlaps the line bit");
   end

   logic                   in_frame;
   logic [TS_W-1:0]        slot;
   logic [BIT_W-1:0]       bit_idx;
   tdm_ctrl_t              ctrl_sh;
   tdm_ctrl_t              ctrl_eff;
   logic [1:0][BYTE_W-1:0] sel_sh;
   logic [1:0][BYTE_W-1:0] sel_eff;
   logic [1:0][BYTE_W-1:0] lane_data;
   logic [1:0]             lane_drive;
   logic [1:0]             lane_bit;
   logic [1:0]             cap_en_v;
   logic [1:0]             drv_en_v;
   logic [1:0]             drv_up;
   logic [1:0]             drv_dn;

   tdm_bit_timer #(.NUM_TS(NUM_TS), .BYTE_W(BYTE_W), .TS_W(TS_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .in_frame (in_frame),
      .slot     (slot),
      .bit_idx  (bit_idx)
   );

   tdm_cfg_regs #(.BYTE_W(BYTE_W)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .ctrl_sh    (ctrl_sh),
      .ctrl_eff   (ctrl_eff),
      .sel_sh     (sel_sh),
      .sel_eff    (sel_eff)
   );

   // monitor claims lane 0: capture forced on, send forced off
   always_comb begin
      cap_en_v[0] = ctrl_eff.in0 | ctrl_eff.mon;
      cap_en_v[1] = ctrl_eff.in1;
      drv_en_v[0] = ctrl_eff.out0 & ~ctrl_eff.mon;
      drv_en_v[1] = ctrl_eff.out1;
   end

   for (genvar i = 0; i < 2; i++) begin : g_lane
      localparam int PEER = 1 - i;
      localparam logic [2:0] DAT_ADDR = (i == 0) ? A_DAT0 : A_DAT1;

      logic              use_peer;
      logic [BYTE_W-1:0] in_sel;

      if (i == 0) begin : g_mon_pin
         assign use_peer = ctrl_eff.swap & ~ctrl_eff.mon;
      end else begin : g_plain
         assign use_peer = ctrl_eff.swap;
      end

      assign in_sel = use_peer ? sel_eff[PEER] : sel_eff[i];

      tdm_slot_lane #(.BYTE_W(BYTE_W), .TS_W(TS_W)) lane_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .in_frame   (in_frame),
         .slot       (slot),
         .bit_idx    (bit_idx),
         .up_in      (up_in),
         .dn_in      (dn_in),
         .cap_en     (cap_en_v[i]),
         .cap_ts     (in_sel[TS_W-1:0]),
         .cap_up     (~in_sel[LINE_B]),
         .drv_en     (drv_en_v[i]),
         .drv_ts     (sel_eff[i][TS_W-1:0]),
         .host_load  (host_wr && (host_addr == DAT_ADDR)),
         .host_wdata (host_wdata),
         .data_q     (lane_data[i]),
         .drive      (lane_drive[i]),
         .drv_bit    (lane_bit[i])
      );

      assign drv_up[i] = lane_drive[i] &  sel_eff[i][LINE_B];
      assign drv_dn[i] = lane_drive[i] & ~sel_eff[i][LINE_B];
   end

   // lane 0 wins if both lanes collide on one line and timeslot
   assign up_oe  = |drv_up;
   assign dn_oe  = |drv_dn;
   assign up_out = drv_up[0] ? lane_bit[0] : (drv_up[1] ? lane_bit[1] : 1'b1);
   assign dn_out = drv_dn[0] ? lane_bit[0] : (drv_dn[1] ? lane_bit[1] : 1'b1);

   always_comb begin
      case (host_raddr)
         A_CTRL:  host_rdata = {{(BYTE_W - CTRL_W){1'b0}}, ctrl_sh};
         A_SEL0:  host_rdata = sel_sh[0];
         A_SEL1:  host_rdata = sel_sh[1];
         A_DAT0:  host_rdata = lane_data[0];
         A_DAT1:  host_rdata = lane_data[1];
         default: host_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tdm_access_chk.sv
module tdm_access_chk
   import tdm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fsync,
   input logic              up_out,
   input logic              up_oe,
   input logic              dn_out,
   input logic              dn_oe,
   input logic              host_wr,
   input logic [2:0]        host_addr,
   input logic [2:0]        host_raddr,
   input logic [BYTE_W-1:0] host_rdata,
   input logic              in_frame,
   input tdm_ctrl_t         ctrl_eff,
   input logic [BYTE_W-1:0] data1_q,
   input logic [1:0]        lane_drive
);

   p_release_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !up_oe |-> up_out);

   p_release_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dn_oe |-> dn_out);

   p_ctrl_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_raddr == 3'd0) |-> (host_rdata[BYTE_W-1:CTRL_W] == '0));

   p_drive_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_oe || dn_oe) |-> in_frame);

   p_hold_no_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_eff.in1 && !(host_wr && host_addr == 3'd4)) |=> $stable(data1_q));

   p_monitor_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_eff.mon |-> !lane_drive[0]);

   p_cfg_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fsync |=> (fsync || $stable(ctrl_eff)));

endmodule

bind tdm_access_unit tdm_access_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .fsync      (fsync),
   .up_out     (up_out),
   .up_oe      (up_oe),
   .dn_out     (dn_out),
   .dn_oe      (dn_oe),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_raddr (host_raddr),
   .host_rdata (host_rdata),
   .in_frame   (in_frame),
   .ctrl_eff   (ctrl_eff),
   .data1_q    (lane_data[1]),
   .lane_drive (lane_drive)
);

// File: tb/tdm_access_unit_tb_top.sv
module tdm_access_unit_tb_top;

   localparam int NTS = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       up_in = 1'b1;
   logic       dn_in = 1'b1;
   logic       up_out, up_oe, dn_out, dn_oe;
   logic       host_wr = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [2:0] host_raddr = '0;
   logic [7:0] host_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   tdm_access_unit dut_i (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .up_in(up_in), .dn_in(dn_in),
      .up_out(up_out), .up_oe(up_oe), .dn_out(dn_out), .dn_oe(dn_oe),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata)
   );

   // kinds: 0 reg read, 1 up byte, 2 dn byte, 3 up oe count, 4 dn oe count,
   //        5 up oe total, 6 dn oe total, 7 idle line state
   typedef struct {
      int         kind;
      int         idx;
      int         val;
      string      req;
   } item_t;

   item_t      sb_q[$];
   logic [7:0] up_b[NTS];
   logic [7:0] dn_b[NTS];
   logic [7:0] obs_up[NTS];
   logic [7:0] obs_dn[NTS];
   int         cnt_up[NTS];
   int         cnt_dn[NTS];

   task automatic push(input int kind, input int idx, input int val, input string req);
      item_t it;
      it.kind = kind; it.idx = idx; it.val = val; it.req = req;
      sb_q.push_back(it);
   endtask

   // monitor: pops expected items and compares with what the design produced
   task automatic drain();
      while (sb_q.size() > 0) begin
         item_t it;
         int    act;
         it  = sb_q.pop_front();
         act = 0;
         case (it.kind)
            0: begin host_raddr = 3'(it.idx); #1; act = int'(host_rdata); end
            1: act = int'(obs_up[it.idx]);
            2: act = int'(obs_dn[it.idx]);
            3: act = cnt_up[it.idx];
            4: act = cnt_dn[it.idx];
            5: for (int t = 0; t < NTS; t++) act += cnt_up[t];
            6: for (int t = 0; t < NTS; t++) act += cnt_dn[t];
            default: begin #1; act = int'({up_out, up_oe, dn_out, dn_oe}); end
         endcase
         checks++;
         if (act != it.val) begin
            fails++;
            $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                     it.req, it.kind, it.idx, act, it.val);
         end
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 3'(addr); host_wdata = 8'(data);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic fill(input logic [7:0] v);
      for (int t = 0; t < NTS; t++) begin up_b[t] = v; dn_b[t] = v; end
   endtask

   task automatic run_frame(input int mid, input int maddr, input int mdata);
      for (int t = 0; t < NTS; t++) begin cnt_up[t] = 0; cnt_dn[t] = 0; end
      for (int b = 0; b < NTS * 8; b++) begin
         int ts;
         int bp;
         ts = b / 8;
         bp = 7 - (b % 8);
         @(negedge clk);
         fsync = (b == 0);
         up_in = up_b[ts][bp];
         dn_in = dn_b[ts][bp];
         if (b == mid) begin
            host_wr = 1'b1; host_addr = 3'(maddr); host_wdata = 8'(mdata);
         end else begin
            host_wr = 1'b0;
         end
         #2;
         obs_up[ts][bp] = up_out;
         obs_dn[ts][bp] = dn_out;
         if (up_oe) cnt_up[ts]++;
         if (dn_oe) cnt_dn[ts]++;
      end
      @(negedge clk);
      fsync = 1'b0; host_wr = 1'b0; up_in = 1'b1; dn_in = 1'b1;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      fill(8'hFF);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state; R6 idle lines released
      for (int a = 0; a < 5; a++) push(0, a, 0, "R1");
      push(7, 0, 4'b1010, "R6");
      drain();

      // R2 upper control bits read zero
      wr(0, 8'hFF);
      push(0, 0, 8'h3F, "R2");
      drain();
      wr(0, 8'h00);

      // R3 capture on opposite lines, MSB first
      wr(1, 8'h03); wr(2, 8'h85); wr(0, 8'h18);
      fill(8'hFF);
      up_b[3] = 8'hA5; dn_b[3] = 8'h11; dn_b[5] = 8'h3C; up_b[5] = 8'hF0;
      run_frame(-1, 0, 0);
      push(0, 3, 8'hA5, "R3");
      push(0, 4, 8'h3C, "R3");
      push(5, 0, 0, "R6");
      push(6, 0, 0, "R6");
      drain();

      // R4 disabled lane keeps its data
      wr(0, 8'h08);
      fill(8'h00);
      up_b[3] = 8'h5A; dn_b[5] = 8'hC3;
      run_frame(-1, 0, 0);
      push(0, 3, 8'h5A, "R4");
      push(0, 4, 8'h3C, "R4");
      drain();

      // R1 data write readback; R5 send on selected line and timeslot
      wr(3, 8'h96); wr(4, 8'h4B);
      push(0, 3, 8'h96, "R1");
      push(0, 4, 8'h4B, "R1");
      drain();
      wr(0, 8'h06);
      fill(8'hFF);
      run_frame(-1, 0, 0);
      push(2, 3, 8'h96, "R5");
      push(4, 3, 8, "R5");
      push(1, 5, 8'h4B, "R5");
      push(3, 5, 8, "R5");
      push(3, 3, 0, "R5");
      push(5, 0, 8, "R5");
      push(6, 0, 8, "R5");
      push(2, 0, 8'hFF, "R6");
      drain();

      // R6 timeslot 13 matches nothing
      wr(1, 8'h0D); wr(0, 8'h02);
      run_frame(-1, 0, 0);
      push(5, 0, 0, "R6");
      push(6, 0, 0, "R6");
      drain();
      wr(1, 8'h03);

      // R7 swap crosses capture selections, sends unchanged
      wr(0, 8'h1F);
      fill(8'h00);
      up_b[3] = 8'h77; dn_b[3] = 8'h88; up_b[5] = 8'h99; dn_b[5] = 8'h22;
      run_frame(-1, 0, 0);
      push(0, 3, 8'h22, "R7");
      push(0, 4, 8'h77, "R7");
      push(2, 3, 8'h96, "R7");
      push(4, 3, 8, "R7");
      push(1, 5, 8'h77, "R7");
      push(3, 5, 8, "R7");
      drain();

      // R8 monitor on downstream timeslot 8 (88h)
      wr(3, 8'h00); wr(1, 8'h88); wr(2, 8'h02); wr(0, 8'h23);
      fill(8'h00);
      dn_b[8] = 8'hE1; up_b[8] = 8'h33; up_b[2] = 8'h44;
      run_frame(-1, 0, 0);
      push(0, 3, 8'hE1, "R8");
      push(0, 4, 8'h77, "R8");
      push(5, 0, 0, "R8");
      push(6, 0, 0, "R8");
      drain();

      // R9 mid-frame control write is deferred to the next sync
      wr(0, 8'h00); wr(1, 8'h06); wr(3, 8'hC3);
      fill(8'hFF);
      run_frame(20, 0, 8'h02);
      push(6, 0, 0, "R9");
      push(0, 0, 8'h02, "R9");
      drain();
      run_frame(-1, 0, 0);
      push(2, 6, 8'hC3, "R9");
      push(4, 6, 8, "R9");
      push(6, 0, 8, "R9");
      drain();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule